// File: doc/BRIEF.md
# Dual-Group DAC Serial Frame Formatter

This block sits between a waveform sequencer and two quad-channel serial DACs. The sequencer hands it one write request at a time. Each request names a board channel (0 to 7), says whether the 16-bit word is an output value or a configuration word, and carries the word. The block turns each request into a 24-bit serial frame. Channels 0 to 3 belong to the first chip and channels 4 to 7 to the second. Each channel is addressed inside its chip by its low two bits.

The two chips share one serial clock and one active-low frame sync, and each chip has its own data line. A frame slot always carries one frame on each line. If both groups have a request waiting, the two frames leave together. If only one group has work, the other line carries a no-op frame so that both chips see a well-formed 24-bit frame. Configuration words are repacked field by field into the frame: the register number, the DAC address (which may be the chip-wide broadcast address 4) and the low four value bits are moved to their frame positions, and every other frame bit is cleared.

Each group holds one waiting request. A new request for a group is accepted only while that group's slot is empty, so the sequencer sees back-pressure per group through the ready output.

Top module: `dac_pair_spi_formatter`

## Requirements
- R1: With `req_cfg`=0 (value request), the frame is: bit 23 = 0, bit 22 = 0, bits 21..19 = 000, bits 18..16 = {0, chan[1:0]}, bits 15..0 = the request word.
- R2: With `req_cfg`=1 (configuration request), frame bits 21..19 = word bits 14..12, bits 18..16 = word bits 10..8 (address 4 passes through unchanged as broadcast), bits 3..0 = word bits 3..0, and bits 23..22 and 15..4 are zero whatever the other word bits hold.
- R3: A request whose channel has bit 2 = 0 is sent on `spi_sdo[0]`, and one with bit 2 = 1 on `spi_sdo[1]`.
- R4: Requests waiting in both groups when a frame starts go out in the same frame. A group with nothing waiting sends the no-op frame 0x180000 (register 011, address 000).
- R5: Frames are sent MSB first, with exactly 24 falling clock edges while sync is low. The data lines change only in cycles where `spi_sclk` rises or `spi_sync_n` changes, and they are stable at every falling edge.
- R6: Sync stays low for exactly 48 x `SCLK_HALF` clock cycles per frame and stays high for at least 2 x `SCLK_HALF` cycles between frames. `spi_sclk` is low whenever sync is high. With the default `SCLK_HALF`=2 the serial clock is a quarter of the system clock.
- R7: `req_ready` is high exactly when the slot of the group chosen by `req_chan[2]` is empty. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and each group sends its requests in acceptance order, one frame per request.
- R8: After reset, `spi_sync_n` is 1, `spi_sclk` is 0, `spi_sdo` is 0 and both groups are ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Slot of the addressed group is empty |
| req_chan | input | 3 | Board channel 0..7 |
| req_cfg | input | 1 | 0 = value word, 1 = configuration word |
| req_word | input | 16 | Request data word |
| spi_sclk | output | 1 | Shared serial clock, idle low |
| spi_sync_n | output | 1 | Shared active-low frame sync |
| spi_sdo | output | 2 | Serial data, bit 0 = channels 0-3, bit 1 = channels 4-7 |

## Verification
The assertions assume a synchronous, active-high reset held for at least one clock. They also assume the request fields hold still while `req_valid` is high and `req_ready` is low, and that nothing but the block drives the serial lines. The stimulus raises `req_valid` only at falling clock edges and keeps it high until the next falling edge after ready is seen. It waits for the frame count to advance before judging a frame. The stimulus also queues requests during a running frame, so that one frame slot carries both groups and back-to-back frames test the minimum sync-high gap.

// File: rtl/dac_pair_pkg.sv
package dac_pair_pkg;

    localparam int FRAME_W      = 24;
    localparam int GROUPS       = 2;
    localparam int CH_PER_GROUP = 4;
    localparam int CH_W         = $clog2(GROUPS * CH_PER_GROUP);
    localparam int LOCAL_W      = $clog2(CH_PER_GROUP);
    localparam int WORD_W       = 16;
    localparam int HALVES       = 2 * FRAME_W;

    localparam logic [2:0] REG_VALUE = 3'b000;
    localparam logic [2:0] REG_MISC  = 3'b011;
    localparam logic [2:0] ADDR_NOP  = 3'b000;

    typedef enum logic {
        REQ_VALUE  = 1'b0,
        REQ_CONFIG = 1'b1
    } req_kind_e;

    typedef struct packed {
        logic        rd_n_wr;
        logic        zero;
        logic [2:0]  reg_sel;
        logic [2:0]  addr;
        logic [15:0] data;
    } spi_frame_s;

    typedef struct packed {
        req_kind_e         kind;
        logic [CH_W-1:0]   chan;
        logic [WORD_W-1:0] word;
    } dac_req_s;

    typedef enum logic [1:0] {
        ENG_IDLE  = 2'd0,
        ENG_SHIFT = 2'd1,
        ENG_GAP   = 2'd2
    } eng_state_e;

    function automatic spi_frame_s value_frame(input logic [LOCAL_W-1:0] local_ch,
                                               input logic [WORD_W-1:0]  w);
        spi_frame_s f;
        f         = '0;
        f.reg_sel = REG_VALUE;
        f.addr    = {1'b0, local_ch};
        f.data    = w;
        return f;
    endfunction

    function automatic spi_frame_s config_frame(input logic [WORD_W-1:0] w);
        spi_frame_s f;
        f           = '0;
        f.reg_sel   = w[14:12];
        f.addr      = w[10:8];
        f.data[3:0] = w[3:0];
        return f;
    endfunction

    function automatic spi_frame_s nop_frame();
        spi_frame_s f;
        f         = '0;
        f.reg_sel = REG_MISC;
        f.addr    = ADDR_NOP;
        return f;
    endfunction

endpackage

// File: rtl/dac_frame_builder.sv
module dac_frame_builder
    import dac_pair_pkg::*;
(
    input  dac_req_s   req,
    output spi_frame_s frame
);

    logic [LOCAL_W-1:0] local_ch;

    assign local_ch = req.chan[LOCAL_W-1:0];

    always_comb begin
        if (req.kind == REQ_CONFIG) begin
            frame = config_frame(req.word);
        end else begin
            frame = value_frame(local_ch, req.word);
        end
    end

endmodule

// File: rtl/dac_group_slot.sv
module dac_group_slot
    import dac_pair_pkg::*;
#(
    parameter int GROUP_ID = 0
)(
    input  logic            clk,
    input  logic            rst,
    input  logic            req_valid,
    input  logic [CH_W-1:0] req_chan,
    input  spi_frame_s      frame_in,
    input  logic            take,
    output logic            pending,
    output logic            free,
    output spi_frame_s      frame_q
);

    localparam logic [CH_W-LOCAL_W-1:0] MY_GROUP = (CH_W-LOCAL_W)'(GROUP_ID);

    logic selected;
    logic accept;

    assign selected = (req_chan[CH_W-1:LOCAL_W] == MY_GROUP);
    assign free     = !pending;
    assign accept   = req_valid && selected && free;

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            frame_q <= '0;
        end else begin
            if (take) begin
                pending <= 1'b0;
            end
            if (accept) begin
                pending <= 1'b1;
                frame_q <= frame_in;
            end
        end
    end

endmodule

// File: rtl/dac_serial_engine.sv
module dac_serial_engine
    import dac_pair_pkg::*;
#(
    parameter int SCLK_HALF = 2
)(
    input  logic                             clk,
    input  logic                             rst,
    input  logic [GROUPS-1:0]                pending,
    input  logic [GROUPS-1:0][FRAME_W-1:0]   frames,
    output logic                             take,
    output logic                             sclk,
    output logic                             sync_n,
    output logic [GROUPS-1:0]                sdo
);

    localparam int HCW  = (SCLK_HALF > 1) ? $clog2(SCLK_HALF) : 1;
    localparam int IDXW = $clog2(HALVES);
    localparam logic [HCW-1:0]  HALF_LAST  = HCW'(SCLK_HALF - 1);
    localparam logic [IDXW-1:0] HALVES_END = IDXW'(HALVES - 1);

    eng_state_e                        state;
    logic [HCW-1:0]                    hcnt;
    logic [IDXW-1:0]                   hidx;
    logic [GROUPS-1:0][FRAME_W-1:0]    sh;
    logic [GROUPS-1:0][FRAME_W-1:0]    launch;
    logic                              half_done;

    assign half_done = (hcnt == HALF_LAST);
    assign take      = (state == ENG_IDLE) && (|pending);

    for (genvar g = 0; g < GROUPS; g++) begin : g_launch
        assign launch[g] = pending[g] ? frames[g] : FRAME_W'(nop_frame());
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ENG_IDLE;
            hcnt   <= '0;
            hidx   <= '0;
            sh     <= '0;
            sclk   <= 1'b0;
            sync_n <= 1'b1;
            sdo    <= '0;
        end else begin
            case (state)
                ENG_IDLE: begin
                    if (take) begin
                        state  <= ENG_SHIFT;
                        hcnt   <= '0;
                        hidx   <= '0;
                        sclk   <= 1'b1;
                        sync_n <= 1'b0;
                        for (int g = 0; g < GROUPS; g++) begin
                            sh[g]  <= launch[g];
                            sdo[g] <= launch[g][FRAME_W-1];
                        end
                    end
                end
                ENG_SHIFT: begin
                    if (!half_done) begin
                        hcnt <= hcnt + 1'b1;
                    end else begin
                        hcnt <= '0;
                        if (hidx == HALVES_END) begin
                            state  <= ENG_GAP;
                            hidx   <= '0;
                            sclk   <= 1'b0;
                            sync_n <= 1'b1;
                            sdo    <= '0;
                        end else begin
                            hidx <= hidx + 1'b1;
                            sclk <= ~sclk;
                            if (hidx[0]) begin
                                for (int g = 0; g < GROUPS; g++) begin
                                    sh[g]  <= sh[g] << 1;
                                    sdo[g] <= sh[g][FRAME_W-2];
                                end
                            end
                        end
                    end
                end
                ENG_GAP: begin
                    if (!half_done) begin
                        hcnt <= hcnt + 1'b1;
                    end else begin
                        hcnt <= '0;
                        if (hidx[0]) begin
                            state <= ENG_IDLE;
                            hidx  <= '0;
                        end else begin
                            hidx <= hidx + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= ENG_IDLE;
                end
            endcase
        end
    end

endmodule

// File: rtl/dac_pair_spi_formatter.sv
module dac_pair_spi_formatter
    import dac_pair_pkg::*;
#(
    parameter int SCLK_HALF = 2
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_chan,
    input  logic        req_cfg,
    input  logic [15:0] req_word,
    output logic        spi_sclk,
    output logic        spi_sync_n,
    output logic [1:0]  spi_sdo
);

    dac_req_s                       req;
    spi_frame_s                     built;
    logic [GROUPS-1:0]              pending;
    logic [GROUPS-1:0]              free;
    logic [GROUPS-1:0][FRAME_W-1:0] frames;
    logic                           take;

    assign req.kind = req_kind_e'(req_cfg);
    assign req.chan = req_chan;
    assign req.word = req_word;

    dac_frame_builder builder_i (
        .req   (req),
        .frame (built)
    );

    for (genvar g = 0; g < GROUPS; g++) begin : g_slot
        spi_frame_s slot_frame;

        dac_group_slot #(.GROUP_ID(g)) slot_i (
            .clk       (clk),
            .rst       (rst),
            .req_valid (req_valid),
            .req_chan  (req_chan),
            .frame_in  (built),
            .take      (take),
            .pending   (pending[g]),
            .free      (free[g]),
            .frame_q   (slot_frame)
        );

        assign frames[g] = slot_frame;
    end

    assign req_ready = free[req_chan[CH_W-1]];

    dac_serial_engine #(.SCLK_HALF(SCLK_HALF)) engine_i (
        .clk     (clk),
        .rst     (rst),
        .pending (pending),
        .frames  (frames),
        .take    (take),
        .sclk    (spi_sclk),
        .sync_n  (spi_sync_n),
        .sdo     (spi_sdo)
    );

endmodule

// File: rtl/dac_pair_spi_formatter_chk.sv
module dac_pair_spi_formatter_chk #(
    parameter int SCLK_HALF = 2
)(
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic       req_ready,
    input logic [2:0] req_chan,
    input logic       spi_sclk,
    input logic       spi_sync_n,
    input logic [1:0] spi_sdo
);

    localparam int LOW_LEN = 48 * SCLK_HALF;
    localparam int GAP_MIN = 2 * SCLK_HALF;
    localparam int LCW     = $clog2(LOW_LEN + 2);

    logic           sclk_q;
    logic [5:0]     fall_cnt;
    logic [LCW-1:0] low_cnt;
    logic [LCW-1:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q   <= 1'b0;
            fall_cnt <= '0;
            low_cnt  <= '0;
            hi_cnt   <= LCW'(GAP_MIN);
        end else begin
            sclk_q <= spi_sclk;
            if (spi_sync_n) begin
                fall_cnt <= '0;
                low_cnt  <= '0;
                if (hi_cnt < LCW'(GAP_MIN)) hi_cnt <= hi_cnt + 1'b1;
            end else begin
                hi_cnt  <= '0;
                low_cnt <= low_cnt + 1'b1;
                if (sclk_q && !spi_sclk) fall_cnt <= fall_cnt + 1'b1;
            end
        end
    end

    // R6
    sclk_idle_low_chk: assert property (@(posedge clk) disable iff (rst)
        spi_sync_n |-> !spi_sclk);

    // R5
    sdo_stable_fall_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sclk) |-> $stable(spi_sdo));

    // R5
    sdo_moves_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(spi_sdo) |-> ($rose(spi_sclk) || !$stable(spi_sync_n)));

    // R5
    bit_count_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sync_n) |-> (fall_cnt == 6'd24));

    // R6
    sync_low_len_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(spi_sync_n) |-> (low_cnt == LCW'(LOW_LEN)));

    // R6
    sync_gap_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_sync_n) |-> (hi_cnt >= LCW'(GAP_MIN)));

    // R7
    ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(req_valid && req_ready) && (req_chan[2] == $past(req_chan[2])))
        |-> !req_ready);

    // R8
    after_reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (spi_sync_n && !spi_sclk && (spi_sdo == 2'b00)));

endmodule

bind dac_pair_spi_formatter dac_pair_spi_formatter_chk #(.SCLK_HALF(SCLK_HALF)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .req_chan   (req_chan),
    .spi_sclk   (spi_sclk),
    .spi_sync_n (spi_sync_n),
    .spi_sdo    (spi_sdo)
);

// File: tb/dac_pair_spi_formatter_tb_top.sv
module dac_pair_spi_formatter_tb_top;

    localparam int HALF = 2;
    localparam logic [23:0] NOP = 24'h180000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_chan = 3'd0;
    logic        req_cfg = 1'b0;
    logic [15:0] req_word = 16'h0;
    logic        spi_sclk;
    logic        spi_sync_n;
    logic [1:0]  spi_sdo;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    dac_pair_spi_formatter #(.SCLK_HALF(HALF)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_chan   (req_chan),
        .req_cfg    (req_cfg),
        .req_word   (req_word),
        .spi_sclk   (spi_sclk),
        .spi_sync_n (spi_sync_n),
        .spi_sdo    (spi_sdo)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // serial receiver
    logic [23:0] rx0 [0:127];
    logic [23:0] rx1 [0:127];
    int          nrx = 0;
    logic        p_sclk = 1'b0, p_sync = 1'b1;
    logic [1:0]  p_sdo = 2'b00;
    logic [23:0] sh0, sh1;
    int          bits = 0, low_len = 0, hi_len = 1000;
    bit          sdo_bad = 0, idle_bad = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if ((spi_sdo != p_sdo) && !(spi_sclk && !p_sclk) && (spi_sync_n == p_sync))
                sdo_bad = 1;
            if (!spi_sync_n) begin
                if (p_sync) begin
                    // R6 gap and idle clock before each frame
                    chk(hi_len >= 2*HALF && !idle_bad, "R6 gap/idle", hi_len, 2*HALF);
                    bits = 0; low_len = 0; sdo_bad = 0; sh0 = '0; sh1 = '0;
                end
                low_len++;
                if (p_sclk && !spi_sclk) begin
                    sh0 = {sh0[22:0], spi_sdo[0]};
                    sh1 = {sh1[22:0], spi_sdo[1]};
                    bits++;
                end
            end else begin
                if (spi_sclk) idle_bad = 1;
                if (!p_sync) begin
                    chk(bits == 24, "R5 bit count", bits, 24);
                    chk(!sdo_bad, "R5 data edge", sdo_bad, 0);
                    chk(low_len == 48*HALF, "R6 sync low length", low_len, 48*HALF);
                    if (nrx < 128) begin
                        rx0[nrx] = sh0;
                        rx1[nrx] = sh1;
                    end
                    nrx++;
                    hi_len = 0; idle_bad = 0;
                end
                hi_len++;
            end
        end
        p_sclk = spi_sclk; p_sync = spi_sync_n; p_sdo = spi_sdo;
    end

    task automatic send(input logic [2:0] ch, input logic cfg, input logic [15:0] w);
        @(negedge clk);
        req_chan = ch; req_cfg = cfg; req_word = w; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_frames(input int n);
        while (nrx < n) @(negedge clk);
    endtask

    function automatic logic [23:0] exp_value(input logic [2:0] ch, input logic [15:0] w);
        return (24'(ch % 4) << 16) | 24'(w);
    endfunction

    function automatic logic [23:0] exp_config(input logic [15:0] w);
        return (24'((w >> 12) & 7) << 19) | (24'((w >> 8) & 7) << 16) | 24'(w & 15);
    endfunction

    task automatic check_pair(input int idx, input logic [23:0] e0, input logic [23:0] e1, input string tag);
        chk(rx0[idx] == e0, {tag, " sdo0"}, rx0[idx], e0);
        chk(rx1[idx] == e1, {tag, " sdo1"}, rx1[idx], e1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d frames", nrx, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int base;
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R8 reset state
        chk(spi_sync_n === 1'b1, "R8 sync_n", spi_sync_n, 1);
        chk(spi_sclk === 1'b0, "R8 sclk", spi_sclk, 0);
        chk(spi_sdo === 2'b00, "R8 sdo", spi_sdo, 0);
        req_chan = 3'd0;
        #1 chk(req_ready === 1'b1, "R8 ready g0", req_ready, 1);
        req_chan = 3'd4;
        #1 chk(req_ready === 1'b1, "R8 ready g1", req_ready, 1);

        // R1 R3 R4: value frame on every channel, idle group padded
        for (int ch = 0; ch < 8; ch++) begin
            logic [15:0] w;
            w = 16'hA5C3 ^ 16'(ch * 16'h1111);
            send(3'(ch), 1'b0, w);
            wait_frames(nrx + 1);
            if (ch < 4) check_pair(nrx - 1, exp_value(3'(ch), w), NOP, "R1 R3 R4 value");
            else        check_pair(nrx - 1, NOP, exp_value(3'(ch), w), "R1 R3 R4 value");
        end

        // R4 R7: queue both groups behind a running frame
        base = nrx;
        send(3'd1, 1'b0, 16'h1234);
        send(3'd2, 1'b0, 16'hBEEF);
        @(negedge clk);
        req_chan = 3'd3;
        #1 chk(req_ready === 1'b0, "R7 group0 busy", req_ready, 0);
        req_chan = 3'd7;
        #1 chk(req_ready === 1'b1, "R7 group1 free", req_ready, 1);
        send(3'd6, 1'b0, 16'h0F0F);
        @(negedge clk);
        req_chan = 3'd5;
        #1 chk(req_ready === 1'b0, "R7 group1 busy", req_ready, 0);
        wait_frames(base + 2);
        check_pair(base, exp_value(3'd1, 16'h1234), NOP, "R4 first slot");
        check_pair(base + 1, exp_value(3'd2, 16'hBEEF), exp_value(3'd6, 16'h0F0F), "R4 shared slot");

        // R7: same group keeps order
        base = nrx;
        send(3'd0, 1'b0, 16'h1111);
        send(3'd3, 1'b0, 16'h2222);
        wait_frames(base + 2);
        check_pair(base, exp_value(3'd0, 16'h1111), NOP, "R7 order first");
        check_pair(base + 1, exp_value(3'd3, 16'h2222), NOP, "R7 order second");

        // R2: every register and address field, junk in the cleared bits
        for (int r = 0; r < 8; r++) begin
            for (int a = 0; a < 8; a++) begin
                logic [15:0] w;
                logic [2:0]  ch;
                w  = {1'b1, 3'(r), 1'b1, 3'(a), 4'hA, 4'((r + a * 3) % 16)};
                ch = 3'((r + a) % 8);
                send(ch, 1'b1, w);
                wait_frames(nrx + 1);
                if (ch < 4) check_pair(nrx - 1, exp_config(w), NOP, "R2 R3 config");
                else        check_pair(nrx - 1, NOP, exp_config(w), "R2 R3 config");
            end
        end

        repeat (20) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule